// File: doc/BRIEF.md
# Programmable Burst Column Sequencer

This block produces the column address for every beat of a memory burst. A controller first loads a 12-bit mode word while clock enable is high; it later pulses a start strobe with the first column and a read/write flag. From the next cycle on, the block presents one column per enabled clock cycle. It also raises a valid flag for the length of the burst and a last flag on the final beat.

The mode word selects a burst of 1, 2, 4 or 8 beats or a whole page. It also selects the beat order: an increment that wraps inside the aligned block, or the start column XORed with the beat number. A separate mode bit makes writes touch a single location while reads keep the programmed length. A stop strobe cuts a finite burst short. A new start on any cycle begins a fresh burst. With clock enable low, everything freezes. Command decoding, CAS latency handling and data timing are left to the surrounding controller.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, valid and last are 0, and the stored mode is a 1-beat sequential burst with no write override. A start issued before any mode load therefore gives one beat at the start column.
- R2: A mode load with clock enable high stores the word. Bits [2:0] give the length: 000 is 1 beat, 001 is 2, 010 is 4, 011 is 8 and 111 is a full page. The codes 100, 101 and 110 give a single beat. Bits [8:4] and [11:10] have no effect on the sequence.
- R3: With bit [3] = 0 (sequential), beat i of a length-L burst that starts at column b is (b with its low log2(L) bits cleared) OR ((b + i) mod L).
- R4: With bit [3] = 1 (interleaved) and a finite length, beat i is b XOR i.
- R5: A full-page burst steps through all 2^COL_W columns in sequential order, even when bit [3] = 1. It wraps from the top column to 0 and never ends by itself. Last stays 0 throughout.
- R6: Last is 1 only on the final beat of a finite burst. Valid is 0 in the enabled cycle after that beat, unless a new start arrives.
- R7: A start taken on any enabled cycle, including mid-burst, shows beat 0 of the new burst in the next cycle. Start takes priority over stop.
- R8: A stop taken on an enabled cycle during a finite burst makes valid 0 in the next cycle. A stop during a full-page burst is ignored.
- R9: When bit [9] = 1, a burst started with the write flag set is one beat long. A read burst keeps the programmed length.
- R10: While clock enable is low, col, valid and last hold their values. Start, stop and mode load are ignored.
- R11: The length, order and write override of a burst are captured at its start. A mode load during the burst affects only later bursts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable; low freezes the block |
| mode_load | input | 1 | Store mode_word this cycle |
| mode_word | input | 12 | Mode word: [2:0] length, [3] order, [9] single write |
| start | input | 1 | Begin a burst at start_col |
| is_write | input | 1 | Burst being started is a write |
| start_col | input | COL_W | First column of the burst |
| stop | input | 1 | End a finite burst early |
| col | output | COL_W | Column of the current beat |
| valid | output | 1 | A beat is being presented |
| last | output | 1 | Current beat is the final one of a finite burst |

## Verification
The hardest state to reach from the ports is a clock-enable stall in the middle of a burst. During that stall, start, stop and a new mode word are all asserted. The bench must show that none of them takes effect. It must also show that the burst resumes at the right beat, and that the next burst still uses the old mode. A directed sequence holds clock enable low for three cycles at beat 1 of an 8-beat burst while driving all three strobes. It then checks the remaining beats and starts a burst with no fresh mode load. A full sweep of every start column, length code and order on a 16-column configuration covers the arithmetic. A full-page run continues past the wrap point and into an ignored stop.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

   localparam int MODE_W = 12;

   typedef struct packed {
      logic [1:0] len_log;   // log2 of finite length (0..3)
      logic       full;      // whole-page burst
      logic       il;        // interleaved order
      logic       wr_single; // writes are one beat
   } bcs_mode_t;

endpackage

// File: rtl/bcs_mode_reg.sv
module bcs_mode_reg
   import bcs_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cke,
   input  logic              load,
   input  logic [MODE_W-1:0] word,
   output bcs_mode_t         mode
);

   bcs_mode_t dec;

   always_comb begin
      dec           = '0;
      dec.il        = word[3];
      dec.wr_single = word[9];
      case (word[2:0])
         3'b000:  dec.len_log = 2'd0;
         3'b001:  dec.len_log = 2'd1;
         3'b010:  dec.len_log = 2'd2;
         3'b011:  dec.len_log = 2'd3;
         3'b111:  dec.full    = 1'b1;
         default: dec.len_log = 2'd0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         mode <= '0;
      else if (cke && load)
         mode <= dec;
   end

   AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      !cke |=> $stable(mode)); // R10

   AST_MODE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      cke && !load |=> $stable(mode)); // R2

endmodule

// File: rtl/bcs_beat_ctr.sv
module bcs_beat_ctr
   import bcs_pkg::*;
#(
   parameter int COL_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cke,
   input  logic             start,
   input  logic             stop,
   input  logic             is_write,
   input  logic [COL_W-1:0] start_col,
   input  bcs_mode_t        mode,
   output logic [COL_W-1:0] base,
   output logic [COL_W-1:0] cnt,
   output logic [COL_W-1:0] mask,
   output logic             il,
   output logic             full,
   output logic             valid,
   output logic             last
);

   localparam logic [COL_W-1:0] ONE  = {{(COL_W-1){1'b0}}, 1'b1};
   localparam logic [COL_W-1:0] ONES = {COL_W{1'b1}};

   logic             one_beat;
   logic             nx_full;
   logic [COL_W-1:0] nx_mask;

   always_comb begin
      one_beat = is_write && mode.wr_single;
      nx_full  = mode.full && !one_beat;
      if (nx_full)
         nx_mask = ONES;
      else if (one_beat)
         nx_mask = '0;
      else
         nx_mask = (ONE << mode.len_log) - ONE;
   end

   assign last = valid && !full && (cnt == mask);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base  <= '0;
         cnt   <= '0;
         mask  <= '0;
         il    <= 1'b0;
         full  <= 1'b0;
         valid <= 1'b0;
      end else if (cke) begin
         if (start) begin
            base  <= start_col;
            cnt   <= '0;
            mask  <= nx_mask;
            il    <= mode.il && !nx_full;
            full  <= nx_full;
            valid <= 1'b1;
         end else if (valid) begin
            if ((stop && !full) || last)
               valid <= 1'b0;
            else
               cnt <= cnt + ONE;
         end
      end
   end

   AST_FULL_NO_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      valid && full |-> !last); // R5

   AST_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      valid && cke && !start && !stop && !last |=> valid && (cnt == $past(cnt) + ONE)); // R3

   AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      valid && cke && stop && !start && !full |=> !valid); // R8

   AST_START_BEAT0: assert property (@(posedge clk) disable iff (!rst_n)
      cke && start |=> valid && (cnt == '0)); // R7

endmodule

// File: rtl/bcs_col_map.sv
module bcs_col_map #(
   parameter int COL_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             valid,
   input  logic [COL_W-1:0] base,
   input  logic [COL_W-1:0] cnt,
   input  logic [COL_W-1:0] mask,
   input  logic             il,
   output logic [COL_W-1:0] col
);

   logic [COL_W-1:0] seq_col;
   logic [COL_W-1:0] xor_col;

   always_comb begin
      seq_col = (base & ~mask) | ((base + cnt) & mask);
      xor_col = base ^ cnt;
      col     = il ? xor_col : seq_col;
   end

   AST_IN_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> (((col ^ base) & ~mask) == '0)); // R3

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
   import bcs_pkg::*;
#(
   parameter int COL_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cke,
   input  logic              mode_load,
   input  logic [MODE_W-1:0] mode_word,
   input  logic              start,
   input  logic              is_write,
   input  logic [COL_W-1:0]  start_col,
   input  logic              stop,
   output logic [COL_W-1:0]  col,
   output logic              valid,
   output logic              last
);

   generate
      if (COL_W < 3 || COL_W > 16) begin : g_bad_width
         $error("burst_col_seq: COL_W must lie in 3..16");
      end
   endgenerate

   bcs_mode_t        mode;
   logic [COL_W-1:0] base;
   logic [COL_W-1:0] cnt;
   logic [COL_W-1:0] mask;
   logic             il;
   logic             full;

   bcs_mode_reg u_mode (
      .clk   (clk),
      .rst_n (rst_n),
      .cke   (cke),
      .load  (mode_load),
      .word  (mode_word),
      .mode  (mode)
   );

   bcs_beat_ctr #(.COL_W(COL_W)) u_ctr (
      .clk       (clk),
      .rst_n     (rst_n),
      .cke       (cke),
      .start     (start),
      .stop      (stop),
      .is_write  (is_write),
      .start_col (start_col),
      .mode      (mode),
      .base      (base),
      .cnt       (cnt),
      .mask      (mask),
      .il        (il),
      .full      (full),
      .valid     (valid),
      .last      (last)
   );

   bcs_col_map #(.COL_W(COL_W)) u_map (
      .clk   (clk),
      .rst_n (rst_n),
      .valid (valid),
      .base  (base),
      .cnt   (cnt),
      .mask  (mask),
      .il    (il),
      .col   (col)
   );

   AST_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      !cke |=> $stable(col) && $stable(valid) && $stable(last)); // R10

   AST_END_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      last && cke && !start |=> !valid); // R6

   AST_LAST_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      last |-> valid); // R6

endmodule

// File: tb/sim_burst_col_seq.sv
`timescale 1ns/1ps
module sim_burst_col_seq;

   localparam int CW = 4;
   localparam int NCOL = 1 << CW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cke = 1'b1;
   logic          mode_load = 1'b0;
   logic [11:0]   mode_word = '0;
   logic          start = 1'b0;
   logic          is_write = 1'b0;
   logic [CW-1:0] start_col = '0;
   logic          stop = 1'b0;
   logic [CW-1:0] col;
   logic          valid;
   logic          last;

   int n_chk = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   burst_col_seq #(.COL_W(CW)) u0 (
      .clk(clk), .rst_n(rst_n), .cke(cke), .mode_load(mode_load),
      .mode_word(mode_word), .start(start), .is_write(is_write),
      .start_col(start_col), .stop(stop), .col(col), .valid(valid), .last(last)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int code_len(input int code);
      case (code)
         1: return 2;
         2: return 4;
         3: return 8;
         7: return NCOL;
         default: return 1;
      endcase
   endfunction

   function automatic int exp_col(input int b, input int i, input int len, input bit xo);
      if (xo) return (b ^ i) & (NCOL - 1);
      return ((b & ~(len - 1)) | ((b + i) & (len - 1))) & (NCOL - 1);
   endfunction

   function automatic logic [11:0] mk_mode(input int code, input bit xo, input bit ws);
      return {2'b00, ws, 2'b00, 3'b010, xo, code[2:0]};
   endfunction

   task automatic load_mode(input logic [11:0] w);
      mode_word = w; mode_load = 1'b1;
      @(negedge clk);
      mode_load = 1'b0;
   endtask

   task automatic start_b(input int c, input bit wr);
      start_col = c[CW-1:0]; is_write = wr; start = 1'b1;
      @(negedge clk);
      start = 1'b0; is_write = 1'b0;
   endtask

   task automatic run_burst(input int b, input int code, input bit xo, input bit wr, input bit ws);
      int  len;
      bit  fp;
      bit  eil;
      int  n;
      string tag;
      len = code_len(code);
      fp  = (code == 7) && !(wr && ws);
      if (wr && ws) len = 1;
      eil = xo && !fp;
      tag = fp ? "R5" : (wr ? "R9" : (eil ? "R4" : "R3"));
      load_mode(mk_mode(code, xo, ws));
      start_b(b, wr);
      n = fp ? len + 3 : len;
      for (int i = 0; i < n; i++) begin
         check({tag, " col"}, int'(col), exp_col(b, i, len, eil));
         check({tag, " valid"}, int'(valid), 1);
         check("R6 last", int'(last), (!fp && i == len - 1) ? 1 : 0);
         @(negedge clk);
      end
      if (!fp) begin
         check("R6 end", int'(valid), 0);
      end else begin
         stop = 1'b1;
         @(negedge clk);
         stop = 1'b0;
         check("R8 full stop ignored", int'(valid), 1);
         check("R8 full col", int'(col), exp_col(b, n + 1, NCOL, 1'b0));
         load_mode(mk_mode(0, 1'b0, 1'b0));
         start_b(0, 1'b0);
         check("R7 restart single", int'(last), 1);
         @(negedge clk);
         check("R6 end", int'(valid), 0);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state and default one-beat mode
      check("R1 valid", int'(valid), 0);
      check("R1 last", int'(last), 0);
      start_b(9, 1'b0);
      check("R1 col", int'(col), 9);
      check("R1 last", int'(last), 1);
      @(negedge clk);
      check("R1 end", int'(valid), 0);

      // R2 R3 R4 R5: sweep of codes, orders and start columns
      for (int code = 0; code < 8; code++)
         for (int xo = 0; xo < 2; xo++)
            for (int b = 0; b < NCOL; b++)
               run_burst(b, code, xo[0], 1'b0, 1'b0);

      // R2: ignored mode bits [8:4] and [11:10]
      load_mode(12'hDF2);
      start_b(6, 1'b0);
      for (int i = 0; i < 4; i++) begin
         check("R2 ignored bits col", int'(col), exp_col(6, i, 4, 1'b0));
         check("R2 ignored bits last", int'(last), (i == 3) ? 1 : 0);
         @(negedge clk);
      end
      check("R2 end", int'(valid), 0);

      // R9: single-location writes
      run_burst(5, 3, 1'b0, 1'b1, 1'b1);
      run_burst(5, 3, 1'b0, 1'b0, 1'b1);
      run_burst(7, 2, 1'b1, 1'b1, 1'b0);
      run_burst(3, 7, 1'b0, 1'b1, 1'b1);

      // R7: restart mid-burst, start over stop
      load_mode(mk_mode(3, 1'b0, 1'b0));
      start_b(2, 1'b0);
      check("R7 col", int'(col), 2);
      @(negedge clk);
      check("R7 col", int'(col), 3);
      stop = 1'b1;
      start_b(13, 1'b0);
      stop = 1'b0;
      check("R7 restart col", int'(col), 13);
      check("R7 restart valid", int'(valid), 1);
      @(negedge clk);
      check("R7 second beat", int'(col), 14);
      @(negedge clk);
      // R8: stop ends a finite burst
      check("R8 before stop", int'(col), 15);
      stop = 1'b1;
      @(negedge clk);
      stop = 1'b0;
      check("R8 stopped", int'(valid), 0);
      check("R8 last", int'(last), 0);

      // R10: clock enable stall with junk strobes
      load_mode(mk_mode(3, 1'b0, 1'b0));
      start_b(1, 1'b0);
      check("R10 beat0", int'(col), 1);
      @(negedge clk);
      check("R10 beat1", int'(col), 2);
      cke = 1'b0; start = 1'b1; start_col = 4'd9; stop = 1'b1;
      mode_load = 1'b1; mode_word = mk_mode(0, 1'b1, 1'b0);
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         check("R10 hold col", int'(col), 2);
         check("R10 hold valid", int'(valid), 1);
         check("R10 hold last", int'(last), 0);
      end
      cke = 1'b1; start = 1'b0; stop = 1'b0; mode_load = 1'b0;
      for (int i = 2; i < 8; i++) begin
         @(negedge clk);
         check("R10 resume col", int'(col), exp_col(1, i, 8, 1'b0));
         check("R10 resume last", int'(last), (i == 7) ? 1 : 0);
      end
      @(negedge clk);
      check("R10 end", int'(valid), 0);

      // R10 R11: mode unchanged by stall; mid-burst load affects later bursts only
      start_b(10, 1'b0);
      for (int i = 0; i < 8; i++) begin
         check("R11 col", int'(col), exp_col(10, i, 8, 1'b0));
         check("R11 last", int'(last), (i == 7) ? 1 : 0);
         if (i == 2) begin
            mode_word = mk_mode(1, 1'b1, 1'b0);
            mode_load = 1'b1;
         end
         @(negedge clk);
         mode_load = 1'b0;
      end
      check("R11 end", int'(valid), 0);
      start_b(5, 1'b0);
      check("R11 new mode beat0", int'(col), 5);
      @(negedge clk);
      check("R11 new mode beat1", int'(col), 4);
      check("R11 new mode last", int'(last), 1);
      @(negedge clk);
      check("R11 new mode end", int'(valid), 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(8 * 150000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule